// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block gathers hardware interrupt requests from sixteen device inputs and turns them into a single interrupt request and an 8-bit vector number for a processor. Inside, two eight-line controller units are chained. The secondary unit's combined request drives line 2 of the primary unit, so the processor sees one controller. Line 2 of the primary unit is reserved for this cascade path, which leaves fifteen usable device inputs.

Each unit latches requests on rising edges and applies its own mask. It picks the lowest-numbered pending line and forwards it only when that line outranks everything the unit already has in service. When the processor pulses acknowledge, the block returns the vector of the winning line for one cycle and moves that line from pending to in-service. An end-of-interrupt command later retires it. A small write port sets the masks, issues end-of-interrupt commands and relocates each unit's vector base. This lets software move hardware vectors out of the range the processor keeps for its own exceptions.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset, `cpu_int` and `vec_valid` are low, both masks are clear, no request is pending or in service, the primary base is 0 and the secondary base is 8.
- R2: `dev_irq[n]` for n in 0..7 drives primary line n, and `dev_irq[n]` for n in 8..15 drives secondary line n-8. `dev_irq[2]` is ignored, because primary line 2 carries only the secondary unit's request.
- R3: A line becomes pending on a 0-to-1 edge of its input. A held-high input produces exactly one request. A request that arrives while its line is masked stays pending.
- R4: A write with `cfg_op`=0 loads `cfg_data` into the mask of the unit chosen by `cfg_sel` (0 = primary, 1 = secondary). Mask bit k set keeps line k from raising an interrupt.
- R5: Within a unit, a lower line number has higher priority. Every secondary request competes at the priority of primary line 2.
- R6: A unit forwards its best pending line only if that line number is strictly lower than every line the unit has in service.
- R7: When `cpu_ack` is high at a clock edge while `cpu_int` is high, `vec_valid` is high for the following cycle and `vec` = {base[7:3], line[2:0]} of the winning line. At the same edge that line leaves pending and enters service. A cascaded grant also puts primary line 2 in service. An acknowledge while `cpu_int` is low gives no `vec_valid`.
- R8: A write with `cfg_op`=2 clears the highest-priority in-service line of the unit chosen by `cfg_sel`. A secondary interrupt needs this command sent to both units before the primary unit again forwards requests of line 2 or lower priority.
- R9: A write with `cfg_op`=1 sets the chosen unit's vector base from `cfg_data`, ignoring its low 3 bits. The new base applies from the next acknowledge. `cfg_op`=3 has no effect.
- R10: If a line's input rises at the same edge that an acknowledge grants it, the line stays pending. If an end-of-interrupt and an acknowledge fall on the same edge in one unit, the end-of-interrupt acts on the lines that were in service before that acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_irq | input | 16 | Device request inputs, bit 2 unused |
| cpu_ack | input | 1 | Processor acknowledge pulse |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Target unit: 0 primary, 1 secondary |
| cfg_op | input | 2 | 0 mask, 1 vector base, 2 end-of-interrupt, 3 none |
| cfg_data | input | 8 | Write data for mask or base |
| cpu_int | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector present on `vec` this cycle |
| vec | output | 8 | Interrupt vector number |

## Verification
Two pairs of events can land on the same edge: an acknowledge that retires a line while that line's input rises again, and an acknowledge together with an end-of-interrupt to the same unit. The bench drives each pair in one cycle. It then judges the outcome only at the ports: it looks for a repeat interrupt after the line is retired, and it checks whether a lower-priority request is still held off. Either of these shows which in-service bits survived.

// File: rtl/irq_casc_pkg.sv
// Shared constants and types for the cascaded interrupt controller.
package irq_casc_pkg;
    localparam int UNIT_LINES   = 8;
    localparam int UNIT_IDX_W   = $clog2(UNIT_LINES);
    localparam int VECTOR_W     = 8;
    localparam int CASCADE_LINE = 2;
    localparam int DEV_LINES    = 2 * UNIT_LINES;

    typedef enum logic [1:0] {
        CFG_MASK = 2'd0,
        CFG_BASE = 2'd1,
        CFG_EOI  = 2'd2,
        CFG_NONE = 2'd3
    } cfg_op_e;
endpackage

// File: rtl/irq_prio_first.sv
// Finds the lowest set bit of a vector (the highest priority).
// Assumes: W >= 2. The outputs are purely combinational.
module irq_prio_first #(
    parameter int W  = 8,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  bits_in,
    output logic          found,
    output logic [IW-1:0] idx,
    output logic [W-1:0]  onehot
);
    // Scan from the top so that the lowest set index is the one kept.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (bits_in[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

    // Isolate the lowest set bit.
    assign onehot = bits_in & (~bits_in + 1'b1);
endmodule

// File: rtl/irq_unit.sv
// One eight-line controller unit: edge latching, masking, priority choice
// against in-service lines, acknowledge and end-of-interrupt handling.
// Assumes: lines flagged in LEVEL_LINES are driven by a level source (the
// cascade input) and are taken as pending straight from the input.
module irq_unit #(
    parameter int                  LINES       = 8,
    parameter int                  VEC_W       = 8,
    parameter logic [LINES-1:0]    LEVEL_LINES = '0,
    parameter logic [VEC_W-1:0]    RESET_BASE  = '0,
    parameter int                  IW          = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] req_in,
    input  logic             ack_in,
    input  logic             mask_we,
    input  logic             base_we,
    input  logic             eoi_we,
    input  logic [VEC_W-1:0] wdata,
    output logic             int_out,
    output logic [IW-1:0]    pick_idx,
    output logic [VEC_W-1:0] vec_out
);
    localparam logic [LINES-1:0] EDGE_LINES = ~LEVEL_LINES;

    logic [LINES-1:0] req_q;
    logic [LINES-1:0] irr_q;
    logic [LINES-1:0] isr_q;
    logic [LINES-1:0] mask_q;
    logic [VEC_W-1:0] base_q;

    logic [LINES-1:0] rise;
    logic [LINES-1:0] irr_eff;
    logic [LINES-1:0] elig;
    logic             pend_found;
    logic [IW-1:0]    pend_idx;
    logic [LINES-1:0] pend_oh;
    logic             isr_found;
    logic [IW-1:0]    isr_idx;
    logic [LINES-1:0] isr_oh;
    logic             take;
    logic [LINES-1:0] take_oh;
    logic [LINES-1:0] eoi_oh;

    // Rising edges of the edge-sensitive inputs.
    assign rise    = req_in & ~req_q & EDGE_LINES;
    // Pending set: latched edge lines plus live level lines.
    assign irr_eff = (irr_q & EDGE_LINES) | (req_in & LEVEL_LINES);
    assign elig    = irr_eff & ~mask_q;

    irq_prio_first #(.W(LINES), .IW(IW)) u_pend (
        .bits_in (elig),
        .found   (pend_found),
        .idx     (pend_idx),
        .onehot  (pend_oh)
    );

    irq_prio_first #(.W(LINES), .IW(IW)) u_serv (
        .bits_in (isr_q),
        .found   (isr_found),
        .idx     (isr_idx),
        .onehot  (isr_oh)
    );

    // Forward only a line that outranks everything in service.
    assign int_out  = pend_found && (!isr_found || (pend_idx < isr_idx));
    assign take     = ack_in && int_out;
    assign take_oh  = take   ? pend_oh : '0;
    assign eoi_oh   = eoi_we ? isr_oh  : '0;
    assign pick_idx = pend_idx;
    assign vec_out  = {base_q[VEC_W-1:IW], pend_idx};

    // Previous input levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_in;
    end

    // Pending register: a new edge wins over a same-cycle grant.
    always_ff @(posedge clk) begin
        if (!rst_n) irr_q <= '0;
        else        irr_q <= ((irr_q & ~take_oh) | rise) & EDGE_LINES;
    end

    // In-service register: EOI sees the pre-grant state; the grant is ORed after it.
    always_ff @(posedge clk) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= (isr_q & ~eoi_oh) | take_oh;
    end

    // Mask register, written whole.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= wdata[LINES-1:0];
    end

    // Vector base, aligned to a block of LINES vectors.
    always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= {RESET_BASE[VEC_W-1:IW], {IW{1'b0}}};
        else if (base_we) base_q <= {wdata[VEC_W-1:IW], {IW{1'b0}}};
    end

    // R7: the granted line is in service after the grant edge.
    a_r7_grant_in_service: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> ((isr_q & $past(pend_oh)) == $past(pend_oh)));

    // R4: a fully masked unit never requests.
    a_r4_full_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '1) |-> !int_out);

    // R6: a line already in service is never forwarded again.
    a_r6_no_equal_forward: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((isr_q & pend_oh) == '0));

    // R8: EOI without a grant retires exactly one in-service line.
    a_r8_eoi_retires_one: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_we && isr_found && !take) |=>
            ($countones(isr_q) + 1 == $countones($past(isr_q))));
endmodule

// File: rtl/irq_cascade_ctrl.sv
// Top of the cascaded controller: wires the secondary unit into the
// primary unit's cascade line, decodes configuration writes and registers
// the vector handed to the processor.
// Assumes: cpu_ack is a single-cycle pulse per acknowledge cycle.
module irq_cascade_ctrl
    import irq_casc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DEV_LINES-1:0] dev_irq,
    input  logic                 cpu_ack,
    input  logic                 cfg_we,
    input  logic                 cfg_sel,
    input  logic [1:0]           cfg_op,
    input  logic [VECTOR_W-1:0]  cfg_data,
    output logic                 cpu_int,
    output logic                 vec_valid,
    output logic [VECTOR_W-1:0]  vec
);
    localparam logic [UNIT_LINES-1:0] PRI_LEVEL = UNIT_LINES'(1) << CASCADE_LINE;
    localparam logic [VECTOR_W-1:0]   SEC_BASE  = VECTOR_W'(UNIT_LINES);

    logic [UNIT_LINES-1:0] pri_req;
    logic [UNIT_LINES-1:0] sec_req;
    logic                  sec_int;
    logic                  pri_int;
    logic [UNIT_IDX_W-1:0] pri_idx;
    logic [UNIT_IDX_W-1:0] sec_idx;
    logic [VECTOR_W-1:0]   pri_vec;
    logic [VECTOR_W-1:0]   sec_vec;
    logic                  via_cascade;
    logic                  sec_ack;
    logic [1:0]            mask_we;
    logic [1:0]            base_we;
    logic [1:0]            eoi_we;
    logic                  unused_dev_line;
    logic                  unused_sec_idx;

    assign unused_dev_line = dev_irq[CASCADE_LINE];
    assign unused_sec_idx  = ^sec_idx;

    // Primary inputs: device lines with the cascade line replaced.
    always_comb begin
        pri_req               = dev_irq[UNIT_LINES-1:0];
        pri_req[CASCADE_LINE] = sec_int;
    end
    assign sec_req = dev_irq[DEV_LINES-1:UNIT_LINES];

    // Per-unit write strobes from the configuration port.
    always_comb begin
        mask_we = '0;
        base_we = '0;
        eoi_we  = '0;
        if (cfg_we) begin
            unique case (cfg_op_e'(cfg_op))
                CFG_MASK: mask_we[cfg_sel] = 1'b1;
                CFG_BASE: base_we[cfg_sel] = 1'b1;
                CFG_EOI:  eoi_we[cfg_sel]  = 1'b1;
                default:  ;
            endcase
        end
    end

    assign via_cascade = (pri_idx == UNIT_IDX_W'(CASCADE_LINE));
    assign sec_ack     = cpu_ack && pri_int && via_cascade;
    assign cpu_int     = pri_int;

    irq_unit #(
        .LINES       (UNIT_LINES),
        .VEC_W       (VECTOR_W),
        .LEVEL_LINES (PRI_LEVEL),
        .RESET_BASE  ('0)
    ) u_primary (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_in   (pri_req),
        .ack_in   (cpu_ack),
        .mask_we  (mask_we[0]),
        .base_we  (base_we[0]),
        .eoi_we   (eoi_we[0]),
        .wdata    (cfg_data),
        .int_out  (pri_int),
        .pick_idx (pri_idx),
        .vec_out  (pri_vec)
    );

    irq_unit #(
        .LINES       (UNIT_LINES),
        .VEC_W       (VECTOR_W),
        .LEVEL_LINES ('0),
        .RESET_BASE  (SEC_BASE)
    ) u_secondary (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_in   (sec_req),
        .ack_in   (sec_ack),
        .mask_we  (mask_we[1]),
        .base_we  (base_we[1]),
        .eoi_we   (eoi_we[1]),
        .wdata    (cfg_data),
        .int_out  (sec_int),
        .pick_idx (sec_idx),
        .vec_out  (sec_vec)
    );

    // Register the granted vector for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid <= 1'b0;
            vec       <= '0;
        end else begin
            vec_valid <= cpu_ack && pri_int;
            if (cpu_ack && pri_int) vec <= via_cascade ? sec_vec : pri_vec;
        end
    end

    // R7: a vector only ever follows an acknowledge.
    a_r7_vec_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(cpu_ack));

    // R5: a cascaded grant always finds the secondary unit requesting.
    a_r5_cascade_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        sec_ack |-> sec_int);
endmodule

// File: tb/sim_irq_cascade_ctrl.sv
module sim_irq_cascade_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] dev_irq = '0;
    logic        cpu_ack = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [1:0]  cfg_op = 2'd3;
    logic [7:0]  cfg_data = '0;
    logic        cpu_int;
    logic        vec_valid;
    logic [7:0]  vec;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    irq_cascade_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .cpu_ack(cpu_ack),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_op(cfg_op), .cfg_data(cfg_data),
        .cpu_int(cpu_int), .vec_valid(vec_valid), .vec(vec)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Rising edge on one device line, released one cycle later.
    task automatic pulse(input int n);
        dev_irq[n] = 1'b1;
        step();
        dev_irq[n] = 1'b0;
    endtask

    task automatic cfg(input bit sel, input int op, input int data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_op = op[1:0]; cfg_data = data[7:0];
        step();
        cfg_we = 1'b0; cfg_op = 2'd3;
    endtask

    task automatic eoi(input bit sel);
        cfg(sel, 2, 0);
    endtask

    // Acknowledge and check the vector that follows, then its drop.
    task automatic ack_expect(input string tag, input int exp_vec);
        cpu_ack = 1'b1;
        step();
        cpu_ack = 1'b0;
        chk({tag, " vec_valid"}, int'(vec_valid), 1);
        chk({tag, " vec"}, int'(vec), exp_vec);
        step();
        chk({tag, " vec_valid drop"}, int'(vec_valid), 0);
    endtask

    task automatic t_reset();
        chk("R1 cpu_int after reset", int'(cpu_int), 0);
        chk("R1 vec_valid after reset", int'(vec_valid), 0);
    endtask

    task automatic t_basic();
        pulse(1);
        chk("R3 edge raises cpu_int", int'(cpu_int), 1);
        ack_expect("R7 R1 default primary vector", 1);
        chk("R7 line retired from pending", int'(cpu_int), 0);
        eoi(0);
        chk("R8 quiet after eoi", int'(cpu_int), 0);
    endtask

    task automatic t_priority();
        dev_irq[5] = 1'b1; dev_irq[3] = 1'b1;
        step();
        dev_irq[5] = 1'b0; dev_irq[3] = 1'b0;
        ack_expect("R5 lower line wins", 3);
        chk("R6 lower priority held off", int'(cpu_int), 0);
        pulse(0);
        chk("R6 higher priority nests", int'(cpu_int), 1);
        ack_expect("R6 nested vector", 0);
        eoi(0);
        chk("R8 eoi clears line 0 only", int'(cpu_int), 0);
        eoi(0);
        chk("R8 eoi clears line 3 then 5 forwards", int'(cpu_int), 1);
        ack_expect("R5 remaining line", 5);
        eoi(0);
    endtask

    task automatic t_mask();
        cfg(0, 0, 8'h10);
        pulse(4);
        chk("R4 masked line quiet", int'(cpu_int), 0);
        cfg(0, 0, 8'h00);
        chk("R3 masked request kept pending", int'(cpu_int), 1);
        ack_expect("R4 unmasked vector", 4);
        eoi(0);
        cfg(1, 0, 8'h01);
        pulse(8);
        chk("R4 secondary mask quiet", int'(cpu_int), 0);
        cfg(1, 0, 8'h00);
        chk("R4 secondary unmask", int'(cpu_int), 1);
        ack_expect("R2 secondary line 0 vector", 8);
        eoi(1); eoi(0);
        chk("R8 both units cleared", int'(cpu_int), 0);
    endtask

    task automatic t_cascade();
        pulse(12);
        chk("R2 secondary line raises cpu_int", int'(cpu_int), 1);
        ack_expect("R7 cascaded vector", 12);
        pulse(3);
        chk("R5 line 3 below cascade priority", int'(cpu_int), 0);
        pulse(1);
        chk("R5 line 1 above cascade", int'(cpu_int), 1);
        ack_expect("R5 line 1 vector", 1);
        eoi(0);
        chk("R7 primary line 2 still in service", int'(cpu_int), 0);
        eoi(0);
        chk("R8 primary eoi frees line 3", int'(cpu_int), 1);
        ack_expect("R8 line 3 vector", 3);
        eoi(0);
        eoi(1);
        dev_irq[9] = 1'b1; dev_irq[14] = 1'b1;
        step();
        dev_irq[9] = 1'b0; dev_irq[14] = 1'b0;
        ack_expect("R5 secondary priority", 9);
        eoi(1);
        chk("R8 secondary eoi alone not enough", int'(cpu_int), 0);
        eoi(0);
        chk("R8 second eoi frees cascade", int'(cpu_int), 1);
        ack_expect("R5 secondary next", 14);
        eoi(1); eoi(0);
        chk("R8 cascade fully retired", int'(cpu_int), 0);
    endtask

    task automatic t_ignored();
        pulse(2);
        chk("R2 dev_irq[2] ignored", int'(cpu_int), 0);
        cfg(0, 3, 8'hFF);
        pulse(6);
        chk("R9 op 3 changes no mask", int'(cpu_int), 1);
        ack_expect("R9 op 3 changes no base", 6);
        eoi(0);
    endtask

    task automatic t_held();
        dev_irq[7] = 1'b1;
        step();
        ack_expect("R3 held line vector", 7);
        eoi(0);
        step();
        chk("R3 held level gives one request", int'(cpu_int), 0);
        dev_irq[7] = 1'b0;
        step();
    endtask

    task automatic t_idle_ack();
        cpu_ack = 1'b1;
        step();
        cpu_ack = 1'b0;
        chk("R7 idle ack gives no vector", int'(vec_valid), 0);
        step();
    endtask

    task automatic t_race();
        pulse(6);
        step();
        dev_irq[6] = 1'b1; cpu_ack = 1'b1;
        step();
        cpu_ack = 1'b0; dev_irq[6] = 1'b0;
        chk("R10 race vector", int'(vec), 6);
        chk("R10 repeat blocked while in service", int'(cpu_int), 0);
        eoi(0);
        chk("R10 new edge kept pending", int'(cpu_int), 1);
        ack_expect("R10 repeat vector", 6);
        eoi(0);
        pulse(3);
        ack_expect("R10 setup line 3", 3);
        pulse(1);
        cpu_ack = 1'b1; cfg_we = 1'b1; cfg_sel = 1'b0; cfg_op = 2'd2;
        step();
        cpu_ack = 1'b0; cfg_we = 1'b0; cfg_op = 2'd3;
        chk("R10 ack with eoi vector", int'(vec), 1);
        pulse(5);
        chk("R10 line 1 in service blocks 5", int'(cpu_int), 0);
        eoi(0);
        chk("R10 eoi removed line 3 earlier", int'(cpu_int), 1);
        ack_expect("R10 line 5 vector", 5);
        eoi(0);
    endtask

    task automatic t_remap();
        cfg(0, 1, 8'h23);
        cfg(1, 1, 8'h2F);
        pulse(5);
        ack_expect("R9 primary remap", 8'h25);
        eoi(0);
        pulse(10);
        ack_expect("R9 secondary remap", 8'h2A);
        eoi(1); eoi(0);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_basic();
        t_priority();
        t_mask();
        t_cascade();
        t_ignored();
        t_held();
        t_idle_ack();
        t_race();
        t_remap();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=0", WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule